// File: doc/BRIEF.md
# Double-Buffered DMA Channel

This block is a single DMA channel run by a host through three 32-bit word registers: control/status, current address and byte count. The host writes a byte count and then an address. The address write commits the pair to the channel. Once the channel is enabled, it walks the region in bursts over a request/grant/done memory interface. Each burst is as long as the selected burst size, or as long as the remaining count if that is smaller. A control bit selects the direction. Reading the address and count registers gives the live pointer and residue while a transfer runs.

With queuing enabled, a second pair can be committed while the first is still moving. When the first pair reaches terminal count, the queued pair becomes current. A pair that arrives while the queue slot is full is dropped, and software reads that condition as busy. Status bits report a device interrupt, a terminal count and a memory error, and an interrupt line is raised when interrupts are enabled. A soft reset aborts the channel at once. If a memory cycle is still outstanding, the channel shows draining and cycle-pending until that cycle returns.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset the control/status register reads as zero except the device ID in bits 31:28. `irq_o` and `mem_req_o` are low.
- R2: A count written at 0x8 and then an address written at 0x4 load the current pair. When bit 9 (DMA enable) and bit 13 (count enable) are set, the channel issues `mem_req_o` at that address. Each request length is the smaller of the remaining count and the burst size. Burst code bits 19:18 select the size: 2'b10 gives 4 bytes, 2'b00 gives 16, 2'b01 gives 32 and 2'b11 gives 64.
- R3: When a cycle completes without error, the address advances by the request length and the count drops by the same amount. Reads at 0x4 and 0x8 return these live values.
- R4: When the count reaches zero, bit 14 (terminal count) is set and bit 26 (current loaded) clears. Bit 0 (interrupt pending) is also set, unless bit 23 (terminal-count interrupt disable) is set. `irq_o` equals (bit 0 or bit 1) and bit 4 (interrupt enable).
- R5: With bit 24 (queue enable) set, a pair committed while a current pair is loaded goes to the queue slot, and bit 27 is set. A further pair is ignored while bit 27 is set. At terminal count the queued pair becomes current and bit 27 clears.
- R6: With bit 24 clear, a pair committed while a current pair is loaded is ignored.
- R7: Bits 0, 1 and 14 clear when written with one. Writing zero to them leaves them unchanged.
- R8: A cycle that completes with `mem_err_i` high sets bit 1 (error pending). The channel then issues no request until a soft reset, even after bit 1 is cleared.
- R9: Writing one to bit 7 clears all control and status bits and both pairs. If a cycle has been granted but not completed, bit 2 (draining) and bit 10 (cycle pending) stay set until `mem_done_i`, and then clear. No request is issued in the meantime.
- R10: A high level on `dev_irq_i` sets bit 0 without setting bit 14.
- R11: `mem_we_o` follows bit 8 (write direction).
- R12: A pair committed while the staged count is zero is not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset (0x0, 0x4, 0x8) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on `reg_addr_i` |
| mem_req_o | output | 1 | Memory cycle request, held until granted |
| mem_gnt_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 32 | Byte address of the cycle |
| mem_len_o | output | 7 | Byte length of the cycle |
| mem_we_o | output | 1 | Direction of the cycle: 1 writes memory |
| mem_done_i | input | 1 | Granted cycle has completed |
| mem_err_i | input | 1 | Error response, qualified by `mem_done_i` |
| dev_irq_i | input | 1 | Device-originated interrupt, level |
| irq_o | output | 1 | Interrupt to the host |

## Verification
The assertions take for granted that the memory side follows the handshake. `mem_gnt_i` is high only while `mem_req_o` is high. A granted cycle gets exactly one `mem_done_i`, and `mem_err_i` counts only together with `mem_done_i`. The stimulus keeps to this contract through a single memory-responder task. That task waits for a request, grants it for one cycle and returns done one cycle later. The drain scenario instead withholds done while the reset is written. Register writes are applied one per cycle, and no grant or done is ever driven without a cycle in flight.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned LEN_W = 7;

  localparam logic [3:0] OFS_CSR  = 4'h0;
  localparam logic [3:0] OFS_ADDR = 4'h4;
  localparam logic [3:0] OFS_CNT  = 4'h8;

  localparam int unsigned B_INT     = 0;
  localparam int unsigned B_ERR     = 1;
  localparam int unsigned B_DRAIN   = 2;
  localparam int unsigned B_IEN     = 4;
  localparam int unsigned B_RESET   = 7;
  localparam int unsigned B_WR      = 8;
  localparam int unsigned B_EN      = 9;
  localparam int unsigned B_CYC     = 10;
  localparam int unsigned B_CNT_EN  = 13;
  localparam int unsigned B_TC      = 14;
  localparam int unsigned B_BURST   = 18;
  localparam int unsigned B_TCI_DIS = 23;
  localparam int unsigned B_NXT_EN  = 24;
  localparam int unsigned B_ACTIVE  = 25;
  localparam int unsigned B_CUR_LD  = 26;
  localparam int unsigned B_NXT_LD  = 27;

  typedef enum logic [1:0] {
    BURST_16B = 2'b00,
    BURST_32B = 2'b01,
    BURST_4B  = 2'b10,
    BURST_64B = 2'b11
  } burst_e;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DRAIN} xfer_st_e;

  function automatic logic [LEN_W-1:0] burst_bytes(input logic [1:0] code);
    case (burst_e'(code))
      BURST_4B:  return LEN_W'(4);
      BURST_16B: return LEN_W'(16);
      BURST_32B: return LEN_W'(32);
      default:   return LEN_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_queue.sv
module dma_chan_queue
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             cnt_we_i,
  input  logic [CW-1:0]    cnt_wdata_i,
  input  logic             addr_we_i,
  input  logic [AW-1:0]    addr_wdata_i,
  input  logic             next_en_i,
  input  logic [1:0]       burst_i,
  input  logic             advance_i,
  output logic [AW-1:0]    cur_addr_o,
  output logic [CW-1:0]    cur_cnt_o,
  output logic             cur_vld_o,
  output logic             nxt_vld_o,
  output logic [LEN_W-1:0] chunk_o,
  output logic             last_o
);
  logic [CW-1:0] stage_cnt_q, cur_cnt_q, nxt_cnt_q;
  logic [AW-1:0] cur_addr_q, nxt_addr_q;
  logic          cur_vld_q, nxt_vld_q;
  logic [CW-1:0] burst_b, chunk_w;
  logic          done_now, load_ok, load_cur, load_nxt;

  assign burst_b  = CW'(burst_bytes(burst_i));
  assign chunk_w  = (cur_cnt_q < burst_b) ? cur_cnt_q : burst_b;
  assign chunk_o  = chunk_w[LEN_W-1:0];
  assign last_o   = cur_vld_q && (cur_cnt_q <= burst_b);
  assign done_now = advance_i && last_o;
  // a full queue slot means busy: the pair is dropped even if promotion frees it this cycle
  assign load_ok  = addr_we_i && !nxt_vld_q && (stage_cnt_q != '0);
  assign load_cur = load_ok && (!cur_vld_q || done_now);
  assign load_nxt = load_ok && !load_cur && next_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_cnt_q <= '0;
      cur_cnt_q   <= '0;
      nxt_cnt_q   <= '0;
      cur_addr_q  <= '0;
      nxt_addr_q  <= '0;
      cur_vld_q   <= 1'b0;
      nxt_vld_q   <= 1'b0;
    end else if (flush_i) begin
      stage_cnt_q <= '0;
      cur_vld_q   <= 1'b0;
      nxt_vld_q   <= 1'b0;
    end else begin
      if (cnt_we_i) stage_cnt_q <= cnt_wdata_i;
      if (advance_i) begin
        cur_addr_q <= cur_addr_q + AW'(chunk_w);
        cur_cnt_q  <= cur_cnt_q - chunk_w;
        if (done_now) begin
          if (nxt_vld_q) begin
            cur_addr_q <= nxt_addr_q;
            cur_cnt_q  <= nxt_cnt_q;
            nxt_vld_q  <= 1'b0;
          end else begin
            cur_vld_q  <= 1'b0;
          end
        end
      end
      if (load_cur) begin
        cur_addr_q <= addr_wdata_i;
        cur_cnt_q  <= stage_cnt_q;
        cur_vld_q  <= 1'b1;
      end
      if (load_nxt) begin
        nxt_addr_q <= addr_wdata_i;
        nxt_cnt_q  <= stage_cnt_q;
        nxt_vld_q  <= 1'b1;
      end
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;
  assign cur_vld_o  = cur_vld_q;
  assign nxt_vld_o  = nxt_vld_q;

  // R5: a queued pair is never overwritten before promotion
  a_r5_next_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nxt_vld_q && !flush_i && !done_now) |=> (nxt_vld_q && $stable(nxt_addr_q)));

  // R3: a non-final cycle lowers the residue by exactly the chunk length
  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !flush_i && !last_o) |=> (cur_cnt_q == $past(cur_cnt_q - chunk_w)));

  // R12: a zero staged count never loads the current slot
  a_r12_zero_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_we_i && !flush_i && !cur_vld_q && (stage_cnt_q == '0)) |=> !cur_vld_q);
endmodule

// File: rtl/dma_chan_xfer.sv
module dma_chan_xfer
  import dma_chan_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_ok_i,
  input  logic abort_i,
  input  logic gnt_i,
  input  logic done_i,
  input  logic err_i,
  output logic req_o,
  output logic advance_o,
  output logic fault_o,
  output logic cyc_pend_o,
  output logic drain_o,
  output logic active_o
);
  xfer_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_ok_i && !abort_i) state_d = ST_REQ;
      ST_REQ:   if (abort_i || !start_ok_i) state_d = ST_IDLE;
                else if (gnt_i)             state_d = ST_WAIT;
      ST_WAIT:  if (done_i)                 state_d = ST_IDLE;
                else if (abort_i)           state_d = ST_DRAIN;
      ST_DRAIN: if (done_i)                 state_d = ST_IDLE;
      default:                              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_o      = (state_q == ST_REQ);
  assign advance_o  = (state_q == ST_WAIT) && done_i && !err_i && !abort_i;
  assign fault_o    = (state_q == ST_WAIT) && done_i && err_i && !abort_i;
  assign cyc_pend_o = (state_q == ST_WAIT) || (state_q == ST_DRAIN);
  assign drain_o    = (state_q == ST_DRAIN);
  assign active_o   = (state_q != ST_IDLE);

  // R2: a request stays up until granted
  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i && !abort_i && start_ok_i) |=> req_o);

  // R9: draining persists until the outstanding cycle returns
  a_r9_drain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_o && !done_i) |=> (drain_o && cyc_pend_o && !req_o));

  // R9: a soft reset withdraws any request
  a_r9_abort_drops_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !req_o);
endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dma_chan_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter logic [3:0]  DEV_ID = 4'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [3:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             mem_req_o,
  input  logic             mem_gnt_i,
  output logic [31:0]      mem_addr_o,
  output logic [LEN_W-1:0] mem_len_o,
  output logic             mem_we_o,
  input  logic             mem_done_i,
  input  logic             mem_err_i,
  input  logic             dev_irq_i,
  output logic             irq_o
);
  localparam int unsigned AW = 32;

  logic csr_we, addr_we, cnt_we, soft_rst;
  logic int_en_q, wr_dir_q, dma_en_q, cnt_en_q, tci_dis_q, nxt_en_q;
  logic [1:0] burst_q;
  logic int_pend_q, err_pend_q, tc_q, halted_q;
  logic [AW-1:0] cur_addr;
  logic [CNT_W-1:0] cur_cnt;
  logic cur_vld, nxt_vld, q_last, start_ok;
  logic x_adv, x_fault, x_cyc, x_drain, x_active;
  logic tc_evt, int_set;
  logic [LEN_W-1:0] chunk;
  logic unused_wdata;

  assign csr_we   = reg_we_i && (reg_addr_i == OFS_CSR);
  assign addr_we  = reg_we_i && (reg_addr_i == OFS_ADDR);
  assign cnt_we   = reg_we_i && (reg_addr_i == OFS_CNT);
  assign soft_rst = csr_we && reg_wdata_i[B_RESET];
  assign unused_wdata = ^reg_wdata_i;

  assign tc_evt   = x_adv && q_last;
  assign int_set  = (tc_evt && !tci_dis_q) || dev_irq_i;
  assign start_ok = cur_vld && dma_en_q && cnt_en_q && !halted_q;

  dma_chan_queue #(.AW(AW), .CW(CNT_W)) u_queue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (soft_rst),
    .cnt_we_i     (cnt_we),
    .cnt_wdata_i  (reg_wdata_i[CNT_W-1:0]),
    .addr_we_i    (addr_we),
    .addr_wdata_i (reg_wdata_i[AW-1:0]),
    .next_en_i    (nxt_en_q),
    .burst_i      (burst_q),
    .advance_i    (x_adv),
    .cur_addr_o   (cur_addr),
    .cur_cnt_o    (cur_cnt),
    .cur_vld_o    (cur_vld),
    .nxt_vld_o    (nxt_vld),
    .chunk_o      (chunk),
    .last_o       (q_last)
  );

  dma_chan_xfer u_xfer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_ok_i (start_ok),
    .abort_i    (soft_rst),
    .gnt_i      (mem_gnt_i),
    .done_i     (mem_done_i),
    .err_i      (mem_err_i),
    .req_o      (mem_req_o),
    .advance_o  (x_adv),
    .fault_o    (x_fault),
    .cyc_pend_o (x_cyc),
    .drain_o    (x_drain),
    .active_o   (x_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {int_en_q, wr_dir_q, dma_en_q, cnt_en_q, tci_dis_q, nxt_en_q} <= '0;
      burst_q    <= 2'b00;
      int_pend_q <= 1'b0;
      err_pend_q <= 1'b0;
      tc_q       <= 1'b0;
      halted_q   <= 1'b0;
    end else if (soft_rst) begin
      {int_en_q, wr_dir_q, dma_en_q, cnt_en_q, tci_dis_q, nxt_en_q} <= '0;
      burst_q    <= 2'b00;
      int_pend_q <= 1'b0;
      err_pend_q <= 1'b0;
      tc_q       <= 1'b0;
      halted_q   <= 1'b0;
    end else begin
      if (csr_we) begin
        int_en_q  <= reg_wdata_i[B_IEN];
        wr_dir_q  <= reg_wdata_i[B_WR];
        dma_en_q  <= reg_wdata_i[B_EN];
        cnt_en_q  <= reg_wdata_i[B_CNT_EN];
        burst_q   <= reg_wdata_i[B_BURST +: 2];
        tci_dis_q <= reg_wdata_i[B_TCI_DIS];
        nxt_en_q  <= reg_wdata_i[B_NXT_EN];
      end
      // write-one-to-clear; a new event in the same cycle wins
      int_pend_q <= (int_pend_q && !(csr_we && reg_wdata_i[B_INT])) || int_set;
      err_pend_q <= (err_pend_q && !(csr_we && reg_wdata_i[B_ERR])) || x_fault;
      tc_q       <= (tc_q && !(csr_we && reg_wdata_i[B_TC])) || tc_evt;
      halted_q   <= halted_q || x_fault;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_CSR: begin
        reg_rdata_o[B_INT]          = int_pend_q;
        reg_rdata_o[B_ERR]          = err_pend_q;
        reg_rdata_o[B_DRAIN]        = x_drain;
        reg_rdata_o[B_IEN]          = int_en_q;
        reg_rdata_o[B_WR]           = wr_dir_q;
        reg_rdata_o[B_EN]           = dma_en_q;
        reg_rdata_o[B_CYC]          = x_cyc;
        reg_rdata_o[B_CNT_EN]       = cnt_en_q;
        reg_rdata_o[B_TC]           = tc_q;
        reg_rdata_o[B_BURST +: 2]   = burst_q;
        reg_rdata_o[B_TCI_DIS]      = tci_dis_q;
        reg_rdata_o[B_NXT_EN]       = nxt_en_q;
        reg_rdata_o[B_ACTIVE]       = x_active;
        reg_rdata_o[B_CUR_LD]       = cur_vld;
        reg_rdata_o[B_NXT_LD]       = nxt_vld;
        reg_rdata_o[31:28]          = DEV_ID;
      end
      OFS_ADDR: reg_rdata_o = cur_addr;
      OFS_CNT:  reg_rdata_o = 32'(cur_cnt);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign mem_addr_o = cur_addr;
  assign mem_len_o  = chunk;
  assign mem_we_o   = wr_dir_q;
  assign irq_o      = int_en_q && (int_pend_q || err_pend_q);

  // R8: a faulted channel stays off the bus
  a_r8_halt_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |-> !mem_req_o);

  // R4: terminal count raises interrupt pending unless suppressed
  a_r4_tc_raises_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_evt && !tci_dis_q && !soft_rst) |=> int_pend_q);

  // R7: a one written to terminal count clears it when no new one arrives
  a_r7_w1c_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we && !soft_rst && reg_wdata_i[B_TC] && !tc_evt) |=> !tc_q);
endmodule

// File: tb/dbuf_dma_chan_tb_top.sv
module dbuf_dma_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] DEV = 4'h9;
  localparam logic [31:0] ID_W = {DEV, 28'h0};
  localparam logic [31:0] M_INT = 32'h1, M_ERR = 32'h2, M_DRAIN = 32'h4, M_IEN = 32'h10;
  localparam logic [31:0] M_RST = 32'h80, M_WR = 32'h100, M_EN = 32'h200, M_CYC = 32'h400;
  localparam logic [31:0] M_CEN = 32'h2000, M_TC = 32'h4000, M_TCID = 32'h80_0000;
  localparam logic [31:0] M_NXEN = 32'h100_0000, M_ACT = 32'h200_0000;
  localparam logic [31:0] M_CLD = 32'h400_0000, M_NLD = 32'h800_0000;
  localparam logic [31:0] W1C = 32'h4003;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic req, gnt = 1'b0, mwe, done = 1'b0, merr = 1'b0, dirq = 1'b0, irq;
  logic [31:0] maddr;
  logic [6:0] mlen;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbuf_dma_chan #(.CNT_W(24), .DEV_ID(DEV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mem_req_o(req), .mem_gnt_i(gnt),
    .mem_addr_o(maddr), .mem_len_o(mlen), .mem_we_o(mwe), .mem_done_i(done),
    .mem_err_i(merr), .dev_irq_i(dirq), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic serve(input logic e, output logic [31:0] a, output logic [6:0] l,
                       output logic w, output logic ok);
    ok = 1'b0; a = '0; l = '0; w = 1'b0;
    for (int i = 0; i < 50 && !ok; i++) begin
      @(negedge clk);
      if (req) ok = 1'b1;
    end
    if (ok) begin
      a = maddr; l = mlen; w = mwe;
      gnt = 1'b1;
      @(negedge clk);
      gnt = 1'b0; done = 1'b1; merr = e;
      @(negedge clk);
      done = 1'b0; merr = 1'b0;
    end
  endtask

  task automatic no_req(input int n, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req) seen = 1'b1;
    end
    chk(tag, {31'b0, seen}, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'h0, v);
    chk("R1 csr after reset", v, ID_W);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 req after reset", {31'b0, req}, 32'h0);
  endtask

  task automatic t_burst(input logic [1:0] code, input logic dir, input int cnt,
                         input logic [31:0] base, input int bb);
    logic [31:0] a, v; logic [6:0] l; logic w, ok;
    int rem = cnt; logic [31:0] pa = base; int ch;
    logic [31:0] ctl = M_EN | M_CEN | (32'(code) << 18) | (dir ? M_WR : 32'h0);
    wr(4'h0, ctl | W1C);
    wr(4'h8, 32'(cnt));
    wr(4'h4, base);
    while (rem > 0) begin
      ch = (rem < bb) ? rem : bb;
      serve(1'b0, a, l, w, ok);
      chk("R2 request seen", {31'b0, ok}, 32'h1);
      if (!ok) break;
      chk("R2 request address", a, pa);
      chk("R2 request length", {25'b0, l}, 32'(ch));
      chk("R11 direction", {31'b0, w}, {31'b0, dir});
      pa += 32'(ch); rem -= ch;
      rd(4'h4, v); chk("R3 live address", v, pa);
      rd(4'h8, v); chk("R3 live residue", v, 32'(rem));
    end
    rd(4'h0, v);
    chk("R4 tc and pending set, current cleared", v & (M_TC | M_INT | M_CLD), M_TC | M_INT);
    chk("R4 irq low with enable clear", {31'b0, irq}, 32'h0);
    wr(4'h0, ctl | M_IEN);
    chk("R4 irq high with enable", {31'b0, irq}, 32'h1);
    wr(4'h0, ctl | M_IEN | M_INT | M_TC);
    rd(4'h0, v);
    chk("R7 w1c clears pending and tc", v & W1C, 32'h0);
    chk("R7 irq dropped", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_queue;
    logic [31:0] a, v; logic [6:0] l; logic w, ok;
    logic [31:0] ctl = M_CEN | M_NXEN;
    wr(4'h0, ctl | W1C);
    wr(4'h8, 32'd8);  wr(4'h4, 32'h3000);
    wr(4'h8, 32'd4);  wr(4'h4, 32'h4000);
    wr(4'h8, 32'd12); wr(4'h4, 32'h5000);
    rd(4'h0, v); chk("R5 both slots loaded", v & (M_CLD | M_NLD), M_CLD | M_NLD);
    rd(4'h4, v); chk("R5 third pair ignored, current addr", v, 32'h3000);
    rd(4'h8, v); chk("R5 current count", v, 32'd8);
    wr(4'h0, ctl | M_EN);
    serve(1'b0, a, l, w, ok);
    chk("R5 first pair served", {a, 25'b0, l}, {32'h3000, 32'd8});
    rd(4'h0, v); chk("R5 promoted, next clear", v & (M_CLD | M_NLD | M_TC), M_CLD | M_TC);
    rd(4'h4, v); chk("R5 promoted address", v, 32'h4000);
    serve(1'b0, a, l, w, ok);
    chk("R5 queued pair served", {a, 25'b0, l}, {32'h4000, 32'd4});
    rd(4'h0, v); chk("R5 current cleared at end", v & M_CLD, 32'h0);
    no_req(20, "R5 dropped pair never runs");
    wr(4'h0, ctl | W1C);
  endtask

  task automatic t_no_queue;
    logic [31:0] v;
    wr(4'h0, M_CEN | W1C);
    wr(4'h8, 32'd16); wr(4'h4, 32'h1100);
    wr(4'h8, 32'd20); wr(4'h4, 32'h2200);
    rd(4'h0, v); chk("R6 next not loaded", v & (M_CLD | M_NLD), M_CLD);
    rd(4'h4, v); chk("R6 current address kept", v, 32'h1100);
    rd(4'h8, v); chk("R6 current count kept", v, 32'd16);
    wr(4'h0, M_RST);
    wr(4'h8, 32'd0); wr(4'h4, 32'h3300);
    rd(4'h0, v); chk("R12 zero count not loaded", v & M_CLD, 32'h0);
  endtask

  task automatic t_error;
    logic [31:0] a, v; logic [6:0] l; logic w, ok;
    logic [31:0] ctl = M_EN | M_CEN | M_IEN;
    wr(4'h0, ctl | W1C);
    wr(4'h8, 32'd32); wr(4'h4, 32'h6000);
    serve(1'b1, a, l, w, ok);
    chk("R8 request before error", {31'b0, ok}, 32'h1);
    rd(4'h0, v); chk("R8 error pending set", v & (M_ERR | M_TC), M_ERR);
    chk("R8 irq on error", {31'b0, irq}, 32'h1);
    no_req(10, "R8 halted after error");
    wr(4'h0, ctl | M_ERR);
    rd(4'h0, v); chk("R7 error pending cleared", v & M_ERR, 32'h0);
    no_req(10, "R8 still halted after clear");
    wr(4'h0, M_RST);
    rd(4'h0, v); chk("R9 reset clears all", v, ID_W);
  endtask

  task automatic t_drain;
    logic [31:0] v; logic ok = 1'b0;
    wr(4'h0, M_EN | M_CEN | W1C);
    wr(4'h8, 32'd16); wr(4'h4, 32'h7000);
    for (int i = 0; i < 50 && !ok; i++) begin
      @(negedge clk);
      if (req) ok = 1'b1;
    end
    chk("R9 request before reset", {31'b0, ok}, 32'h1);
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    wr(4'h0, M_RST);
    rd(4'h0, v); chk("R9 draining", v, ID_W | M_ACT | M_CYC | M_DRAIN);
    no_req(5, "R9 no request while draining");
    rd(4'h0, v); chk("R9 still draining", v & (M_DRAIN | M_CYC), M_DRAIN | M_CYC);
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    rd(4'h0, v); chk("R9 drain done", v, ID_W);
  endtask

  task automatic t_dev_irq;
    logic [31:0] v;
    wr(4'h0, W1C);
    @(negedge clk); dirq = 1'b1;
    @(negedge clk); dirq = 1'b0;
    rd(4'h0, v); chk("R10 device irq pending without tc", v & (M_INT | M_TC), M_INT);
    wr(4'h0, M_IEN);
    chk("R10 irq output", {31'b0, irq}, 32'h1);
    wr(4'h0, M_IEN | M_INT);
    chk("R10 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_tci_dis;
    logic [31:0] a, v; logic [6:0] l; logic w, ok;
    wr(4'h0, M_EN | M_CEN | M_IEN | M_TCID | (32'h2 << 18) | W1C);
    wr(4'h8, 32'd4); wr(4'h4, 32'h8000);
    serve(1'b0, a, l, w, ok);
    chk("R4 tci-disabled transfer", {a, 25'b0, l}, {32'h8000, 32'd4});
    rd(4'h0, v); chk("R4 tc without pending", v & (M_TC | M_INT), M_TC);
    chk("R4 no irq when tc interrupt disabled", {31'b0, irq}, 32'h0);
    wr(4'h0, M_RST);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_burst(2'b10, 1'b0, 10,  32'h1000, 4);
    t_burst(2'b00, 1'b1, 20,  32'h1800, 16);
    t_burst(2'b01, 1'b0, 40,  32'h2000, 32);
    t_burst(2'b11, 1'b1, 100, 32'h2400, 64);
    t_queue();
    t_no_queue();
    t_error();
    t_drain();
    t_dev_irq();
    t_tci_dis();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule